// File: doc/BRIEF.md
# Multiprocessor Block-Start Serial Transmitter

This block is an asynchronous serial transmitter for multiprocessor links that separate message blocks by idle time on the line. A host places one byte at a time into a single-entry holding buffer. When the frame shifter is free, on a baud tick, the byte moves into the shifter and goes out as a character frame.

To mark the start of a new block, the host first raises a wake request and then writes a dummy byte. When that dummy byte moves into the shifter, the wake request moves with it into a temporary wake latch and is cleared. The shifter then keeps the line high for exactly one frame time in place of the character. Because the buffer and the shifter, and the wake request and the wake latch, each form a two-stage pair, the host can queue the address byte of the new block while the gap is still going out. The address frame then follows the gap with no extra idle time.

Bit timing comes from a baud tick input that pulses once per bit time. The data length and the parity options are parameters.

Top module: `mp_blockstart_tx`

## Requirements
- R1: After reset, tx_o is 1, buf_empty_o is 1, shf_empty_o is 1 and wake_req_o is 0.
- R2: A character frame holds FRAME_BITS = DATA_W + 2 + PARITY_EN bits (11 by default), each lasting one baud tick interval. The order is: a start bit of 0, then DATA_W data bits with the LSB first, then a parity bit when PARITY_EN=1, then a stop bit of 1. The parity bit is the XOR of the data bits, further XORed with PARITY_ODD (0 by default, which gives even parity).
- R3: A byte moves from the buffer into the shifter only in a cycle where baud_tick is 1. That cycle is either one in which the shifter is idle, or the tick that ends the last bit of the current frame. A queued byte therefore starts straight after the previous stop bit, with no idle bit between the frames.
- R4: buf_empty_o goes to 0 in the cycle after an accepted write. It returns to 1 in the cycle after the byte moves into the shifter.
- R5: A write with wr_data_en=1 while buf_empty_o is 0 is ignored. The byte already waiting is the one that is sent, and the ignored byte never appears on the line.
- R6: A pulse on wr_wake_en sets wake_req_o. If the buffer is full, the request applies to the byte already waiting. If the buffer is empty, it applies to the next byte written. wake_req_o is 0 again in the cycle after that byte moves into the shifter.
- R7: A byte carried with a wake request is never sent. The line stays high for exactly FRAME_BITS tick intervals, starting straight after the stop bit of the previous frame.
- R8: Once the dummy byte has moved into the shifter, the next byte written (the address byte) can be queued. It starts after exactly FRAME_BITS high bits that follow the last stop bit. Two wake frames in a row give 2*FRAME_BITS high bits.
- R9: shf_empty_o is 0 from the cycle after a load until the last bit of the frame completes with nothing waiting. For a byte loaded into an idle shifter, this is FRAME_BITS tick intervals after buf_empty_o returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| wr_data_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | DATA_W | Byte to send |
| wr_wake_en | input | 1 | Sets the wake request |
| wake_req_o | output | 1 | Current wake request |
| buf_empty_o | output | 1 | Holding buffer can accept a byte |
| shf_empty_o | output | 1 | Shifter idle, line idle |
| tx_o | output | 1 | Serial output, idles high |

## Verification
A wake request that is held too long or cleared too early turns an ordinary byte into a gap, or lets a dummy byte onto the line. At the ports this shows as a missing or extra decoded character, or as a high run other than 11 bits ahead of the address frame, within the next frame time. A bit counter or shift register that is off by one shows on the very next frame, as a wrong data or parity bit, a low stop bit, or a shifter-empty flag that rises earlier or later than 11 tick intervals after a load. A buffer flag or write guard that is wrong shows as a dropped or duplicated byte in the decoded stream.

// File: rtl/mpbs_pkg.sv
package mpbs_pkg;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_BUSY = 1'b1
    } sh_state_e;

    function automatic int frame_bits(input int data_w, input int parity_en);
        return data_w + 2 + parity_en;
    endfunction

endpackage

// File: rtl/mpbs_txbuf.sv
module mpbs_txbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_wake_en,
    input  logic              load_i,
    output logic [DATA_W-1:0] data_o,
    output logic              wake_o,
    output logic              full_o
);

    typedef struct packed {
        logic              full;
        logic              wake;
        logic [DATA_W-1:0] data;
    } buf_state_t;

    buf_state_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (load_i) begin
            buf_d.full = 1'b0;
            buf_d.wake = 1'b0;
        end
        if (wr_data_en && !buf_q.full) begin
            buf_d.full = 1'b1;
            buf_d.data = wr_data;
        end
        if (wr_wake_en) begin
            buf_d.wake = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign data_o = buf_q.data;
    assign wake_o = buf_q.wake;
    assign full_o = buf_q.full;

    AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_q.full && !load_i) |=> (full_o && $stable(data_o))); // R5

    AST_LOAD_DROPS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !wr_wake_en) |=> !wake_o); // R6

    AST_LOAD_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> full_o); // R3

endmodule

// File: rtl/mpbs_framer.sv
module mpbs_framer #(
    parameter int DATA_W     = 8,
    parameter int PARITY_EN  = 1,
    parameter int PARITY_ODD = 0
) (
    input  logic [DATA_W-1:0]                                    data_i,
    input  logic                                                 wake_i,
    output logic [mpbs_pkg::frame_bits(DATA_W, PARITY_EN)-1:0] frame_o
);

    localparam int FRAME_BITS = mpbs_pkg::frame_bits(DATA_W, PARITY_EN);

    logic [FRAME_BITS-1:0] char_frame;

    generate
        if (PARITY_EN != 0) begin : g_parity
            logic par_bit;
            assign par_bit    = (^data_i) ^ (PARITY_ODD != 0);
            assign char_frame = {1'b1, par_bit, data_i, 1'b0};
        end else begin : g_no_parity
            assign char_frame = {1'b1, data_i, 1'b0};
        end
    endgenerate

    always_comb begin
        if (wake_i) begin
            frame_o = '1;
        end else begin
            frame_o = char_frame;
        end
    end

endmodule

// File: rtl/mpbs_shifter.sv
module mpbs_shifter #(
    parameter int FRAME_BITS = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  baud_tick,
    input  logic                  pend_i,
    input  logic [FRAME_BITS-1:0] frame_i,
    input  logic                  wake_i,
    output logic                  load_o,
    output logic                  tx_o,
    output logic                  idle_o
);

    localparam int CNT_W = $clog2(FRAME_BITS);

    typedef struct packed {
        mpbs_pkg::sh_state_e   st;
        logic [FRAME_BITS-1:0] sr;
        logic [CNT_W-1:0]      cnt;
        logic                  wut;
    } sh_state_t;

    sh_state_t sh_d, sh_q;
    logic      last_bit;
    logic      load;

    assign last_bit = (sh_q.cnt == CNT_W'(FRAME_BITS - 1));

    always_comb begin
        sh_d = sh_q;
        load = 1'b0;
        if (baud_tick) begin
            if (sh_q.st == mpbs_pkg::SH_IDLE) begin
                load = pend_i;
            end else if (last_bit) begin
                if (pend_i) begin
                    load = 1'b1;
                end else begin
                    sh_d.st  = mpbs_pkg::SH_IDLE;
                    sh_d.sr  = '1;
                    sh_d.cnt = '0;
                    sh_d.wut = 1'b0;
                end
            end else begin
                sh_d.cnt = sh_q.cnt + 1'b1;
                sh_d.sr  = {1'b1, sh_q.sr[FRAME_BITS-1:1]};
            end
        end
        if (load) begin
            sh_d.st  = mpbs_pkg::SH_BUSY;
            sh_d.sr  = frame_i;
            sh_d.cnt = '0;
            sh_d.wut = wake_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q.st  <= mpbs_pkg::SH_IDLE;
            sh_q.sr  <= '1;
            sh_q.cnt <= '0;
            sh_q.wut <= 1'b0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign load_o = load;
    assign tx_o   = sh_q.sr[0];
    assign idle_o = (sh_q.st == mpbs_pkg::SH_IDLE);

    AST_LOAD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> baud_tick); // R3

    AST_GAP_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.wut && !idle_o) |-> tx_o); // R7

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o && !wake_i) |=> !tx_o); // R2

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> tx_o); // R1

    AST_BIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(tx_o)); // R2

endmodule

// File: rtl/mp_blockstart_tx.sv
module mp_blockstart_tx #(
    parameter int DATA_W     = 8,
    parameter int PARITY_EN  = 1,
    parameter int PARITY_ODD = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_data_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_wake_en,
    output logic              wake_req_o,
    output logic              buf_empty_o,
    output logic              shf_empty_o,
    output logic              tx_o
);

    localparam int FRAME_BITS = mpbs_pkg::frame_bits(DATA_W, PARITY_EN);

    logic [DATA_W-1:0]     pend_data;
    logic                  pend_wake;
    logic                  pend_full;
    logic                  load;
    logic [FRAME_BITS-1:0] frame;

    mpbs_txbuf #(
        .DATA_W (DATA_W)
    ) u_txbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_data_en (wr_data_en),
        .wr_data    (wr_data),
        .wr_wake_en (wr_wake_en),
        .load_i     (load),
        .data_o     (pend_data),
        .wake_o     (pend_wake),
        .full_o     (pend_full)
    );

    mpbs_framer #(
        .DATA_W     (DATA_W),
        .PARITY_EN  (PARITY_EN),
        .PARITY_ODD (PARITY_ODD)
    ) u_framer (
        .data_i  (pend_data),
        .wake_i  (pend_wake),
        .frame_o (frame)
    );

    mpbs_shifter #(
        .FRAME_BITS (FRAME_BITS)
    ) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .pend_i    (pend_full),
        .frame_i   (frame),
        .wake_i    (pend_wake),
        .load_o    (load),
        .tx_o      (tx_o),
        .idle_o    (shf_empty_o)
    );

    assign buf_empty_o = !pend_full;
    assign wake_req_o  = pend_wake;

    AST_EMPTY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (buf_empty_o && !shf_empty_o)); // R4

endmodule

// File: tb/mp_blockstart_tx_bench.sv
module mp_blockstart_tx_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int DATA_W     = 8;
    localparam int FB         = DATA_W + 3;
    localparam int NV         = 9;
    // {wake, data, expected high bits before this frame (FF = not checked)}
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 8'h55, 8'hFF},
        {1'b0, 8'hA3, 8'd0},
        {1'b1, 8'hFF, 8'hFF},
        {1'b0, 8'h81, 8'd11},
        {1'b0, 8'h00, 8'd0},
        {1'b1, 8'h12, 8'hFF},
        {1'b1, 8'h34, 8'hFF},
        {1'b0, 8'hC7, 8'd22},
        {1'b0, 8'h7E, 8'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud_tick = 1'b0;
    logic wr_data_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic wr_wake_en = 1'b0;
    logic wake_req_o, buf_empty_o, shf_empty_o, tx_o;

    int checks = 0;
    int failures = 0;

    mp_blockstart_tx u_mp_blockstart_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .baud_tick   (baud_tick),
        .wr_data_en  (wr_data_en),
        .wr_data     (wr_data),
        .wr_wake_en  (wr_wake_en),
        .wake_req_o  (wake_req_o),
        .buf_empty_o (buf_empty_o),
        .shf_empty_o (shf_empty_o),
        .tx_o        (tx_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // line decoder, one sample per bit time
    int div_cnt = 0;
    int ones_run = 0;
    int rx_pos = -1;
    int cur_gap = 0;
    logic [DATA_W-1:0] rx_sh = '0;
    logic rx_par = 1'b0;
    int rx_n = 0;
    logic [DATA_W-1:0] rx_byte [64];
    int rx_gap [64];
    logic rx_par_bit [64];
    logic rx_stop [64];

    always @(negedge clk) begin
        if (baud_tick && rst_n) begin
            if (rx_pos < 0) begin
                if (tx_o == 1'b0) begin
                    cur_gap = ones_run;
                    rx_pos = 1;
                end else begin
                    ones_run = ones_run + 1;
                end
            end else if (rx_pos <= DATA_W) begin
                rx_sh[rx_pos-1] = tx_o;
                rx_pos = rx_pos + 1;
            end else if (rx_pos == DATA_W + 1) begin
                rx_par = tx_o;
                rx_pos = rx_pos + 1;
            end else begin
                if (rx_n < 64) begin
                    rx_byte[rx_n] = rx_sh;
                    rx_gap[rx_n] = cur_gap;
                    rx_par_bit[rx_n] = rx_par;
                    rx_stop[rx_n] = tx_o;
                    rx_n = rx_n + 1;
                end
                ones_run = 0;
                rx_pos = -1;
            end
        end
        baud_tick = (div_cnt == 0);
        div_cnt = (div_cnt + 1) % TICK_DIV;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [DATA_W-1:0] d, input bit wake);
        do @(negedge clk); while (!buf_empty_o);
        if (wake) begin
            wr_wake_en = 1'b1;
            @(negedge clk);
            wr_wake_en = 1'b0;
        end
        wr_data_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_data_en = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(buf_empty_o && shf_empty_o));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int base;
        int j;
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(tx_o == 1'b1, "R1 tx idle", tx_o, 1);
        check(buf_empty_o == 1'b1, "R1 buf_empty", buf_empty_o, 1);
        check(shf_empty_o == 1'b1, "R1 shf_empty", shf_empty_o, 1);
        check(wake_req_o == 1'b0, "R1 wake_req", wake_req_o, 0);

        // vector walk
        for (int i = 0; i < NV; i++) begin
            write_byte(VEC[i][15:8], VEC[i][16]);
        end
        wait_idle();
        j = 0;
        for (int i = 0; i < NV; i++) begin
            if (!VEC[i][16]) begin
                check(rx_byte[j] == VEC[i][15:8], "R2 data", rx_byte[j], VEC[i][15:8]);
                check(rx_par_bit[j] == ^VEC[i][15:8], "R2 parity", rx_par_bit[j], ^VEC[i][15:8]);
                check(rx_stop[j] == 1'b1, "R2 stop", rx_stop[j], 1);
                if (VEC[i][7:0] != 8'hFF) begin
                    check(rx_gap[j] == int'(VEC[i][7:0]), "R8 gap before frame (R3 R7)",
                          rx_gap[j], VEC[i][7:0]);
                end
                j++;
            end
        end
        check(rx_n == 6, "R7 dummy bytes not sent", rx_n, 6);

        // R5: write to full buffer ignored
        base = rx_n;
        write_byte(8'h3C, 1'b0);
        write_byte(8'hC3, 1'b0);
        wr_data_en = 1'b1;
        wr_data = 8'h99;
        @(negedge clk);
        wr_data_en = 1'b0;
        check(buf_empty_o == 1'b0, "R4 buffer still full", buf_empty_o, 0);
        wait_idle();
        check(rx_n == base + 2, "R5 frame count", rx_n - base, 2);
        check(rx_byte[base] == 8'h3C, "R5 first byte", rx_byte[base], 8'h3C);
        check(rx_byte[base+1] == 8'hC3, "R5 pending byte kept", rx_byte[base+1], 8'hC3);

        // R4 / R9 timing on a single frame
        base = rx_n;
        write_byte(8'h5A, 1'b0);
        check(buf_empty_o == 1'b0, "R4 full after write", buf_empty_o, 0);
        check(shf_empty_o == 1'b1, "R9 idle before load", shf_empty_o, 1);
        do @(negedge clk); while (!buf_empty_o);
        check(shf_empty_o == 1'b0, "R9 busy at load", shf_empty_o, 0);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!shf_empty_o && cyc < 1000);
        check(cyc == FB * TICK_DIV, "R9 frame duration", cyc, FB * TICK_DIV);
        check(rx_byte[base] == 8'h5A, "R2 single byte", rx_byte[base], 8'h5A);

        // R6: wake set while buffer full applies to the waiting byte
        base = rx_n;
        write_byte(8'h11, 1'b0);
        write_byte(8'hDD, 1'b0);
        wr_wake_en = 1'b1;
        @(negedge clk);
        wr_wake_en = 1'b0;
        check(wake_req_o == 1'b1, "R6 wake request set", wake_req_o, 1);
        do @(negedge clk); while (!buf_empty_o);
        check(wake_req_o == 1'b0, "R6 wake cleared on load", wake_req_o, 0);
        write_byte(8'h22, 1'b0);
        repeat (5) @(negedge clk);
        check(tx_o == 1'b1, "R7 line high in gap", tx_o, 1);
        check(shf_empty_o == 1'b0, "R9 busy during gap", shf_empty_o, 0);
        wait_idle();
        check(rx_n == base + 2, "R6 waiting byte suppressed", rx_n - base, 2);
        check(rx_byte[base+1] == 8'h22, "R8 address byte", rx_byte[base+1], 8'h22);
        check(rx_gap[base+1] == FB, "R7 gap length", rx_gap[base+1], FB);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule